// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor that runs a program from a 16-word memory. Every instruction goes through the same fixed sequence: fetch, decode, operand read, execute and write-back. The core has a program counter, an instruction register and three 32-bit general registers. Register 0 doubles as the accumulator. Each 32-bit instruction word packs four fields, from the top bit down: a 4-bit opcode at bits 31:28, a 2-bit addressing mode at bits 27:26, a 2-bit register select at bits 25:24, and a 24-bit operand field at bits 23:0.

The memory sits outside the core and has a synchronous read. Read data appears on the cycle after the address is presented. The core drives one address bus for instruction fetch, operand reads and stores, and a write strobe for stores.

The logical instructions give the truth values 0 and 1 rather than bitwise results, and so do the compare instructions. The operand X comes from one of three places:
- the accumulator;
- the sign-extended 24-bit field;
- the memory word at the address held in the field.

Errors end in a halt with a sticky error flag, with one exception. A divide by zero only sets the flag and execution goes on. The core exposes its halt state and debug copies of PC, IR and the three registers.

Top module: `toy_cpu`

## Requirements
- R1: Every legal instruction takes exactly five clock cycles. A program of n instructions ending in HLT (opcode 0001) raises `halted` 5*n cycles after reset is released.
- R2: During reset, PC, IR, R0, R1 and R2 read 0, and `halted` and `errFlag` are low. The first fetch uses address 0.
- R3: The operand X depends on the addressing mode. Mode 00 gives R0. Mode 01 gives the 24-bit field sign-extended to 32 bits. Mode 10 gives the memory word at the address in the low 4 bits of the field. LOD (0100) writes X into the selected register.
- R4: Register select 00, 01 and 10 pick R0, R1 and R2, and an instruction writes only the register it selects.
- R5: ADD (0110), SUB (0111), MUL (1000) and DIV (1001) write back reg+X, reg-X, the low 32 bits of reg*X, and the signed quotient of reg/X truncated toward zero.
- R6: AND (1010) writes 1 when both reg and X are non-zero, and 0 otherwise. OR (1011) writes 0 only when both are zero, and 1 otherwise.
- R7: NOT (1100) writes the bitwise complement of reg. CPZ (1101) writes 1 when X is zero, else 0. CPL (1110) writes 1 when bit 31 of X is set, else 0.
- R8: STO (0101) writes the selected register to memory. In mode 10 the target address is the low 4 bits of the field. In mode 00 it is the low 4 bits of R0. No other opcode writes memory.
- R9: JMP (0010) loads PC with the low 4 bits of X and ignores the register select. JMZ (0011) does the same only when the selected register is zero. Otherwise PC holds the address after the instruction.
- R10: After HLT, `halted` stays high, and PC and all registers hold their values until reset. No memory write happens while halted.
- R11: These cases raise `halted` and `errFlag` three cycles after the fetch begins, with no register or memory change:
  - opcode 1111;
  - mode 11 on any opcode other than NOP (0000) and HLT;
  - mode 01 on STO;
  - register select 11 on any opcode other than NOP, HLT and JMP.
- R12: DIV with X equal to 0 leaves the register unchanged, sets `errFlag` and lets execution continue.
- R13: Once set, `errFlag` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 4 | Memory address for fetch, operand read or store |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Read data, valid one cycle after the address |
| halted | output | 1 | Core has stopped |
| errFlag | output | 1 | Sticky error indication |
| dbgPc | output | 4 | Program counter |
| dbgIr | output | 32 | Instruction register |
| dbgR0 | output | 32 | Register 0 (accumulator) |
| dbgR1 | output | 32 | Register 1 |
| dbgR2 | output | 32 | Register 2 |

## Verification
The arithmetic, truth-valued and compare instructions are each run as a short program. The program takes its operands from memory, and the instruction is tried in each of the three addressing modes, so a wrong operand source gives a wrong result. Negative immediates tell sign extension apart from zero extension, and a subtract across the 32-bit wrap exposes a narrowed datapath. A jump program with one taken and one untaken conditional branch separates the two outcomes by the registers and the PC it leaves behind. The illegal encodings, the divide-by-zero case and the accumulator-addressed store are each driven on their own, and the bench checks the registers, the memory and the cycle count afterwards.

// File: rtl/toy_pkg.sv
package toy_pkg;

  typedef enum logic [3:0] {
    OP_NOP = 4'h0, OP_HLT = 4'h1, OP_JMP = 4'h2, OP_JMZ = 4'h3,
    OP_LOD = 4'h4, OP_STO = 4'h5, OP_ADD = 4'h6, OP_SUB = 4'h7,
    OP_MUL = 4'h8, OP_DIV = 4'h9, OP_AND = 4'hA, OP_OR  = 4'hB,
    OP_NOT = 4'hC, OP_CPZ = 4'hD, OP_CPL = 4'hE, OP_BAD = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {
    AM_ACC = 2'b00, AM_IMM = 2'b01, AM_DIR = 2'b10, AM_BAD = 2'b11
  } amode_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_OPERAND, ST_EXECUTE, ST_WRITEBACK, ST_HALT
  } state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic irLoad;   // capture fetched word, advance PC
    logic opRead;   // put operand address on the memory bus
    logic exLatch;  // capture ALU result and side decisions
    logic commit;   // apply register, PC and memory updates
  } strobe_t;

  function automatic logic writesReg(opcode_e op);
    return (op == OP_LOD) || (op >= OP_ADD && op <= OP_CPL);
  endfunction

endpackage

// File: rtl/toy_alu.sv
module toy_alu
  import toy_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  opcode_e           op,
  input  logic [DATA_W-1:0] regVal,
  input  logic [DATA_W-1:0] xVal,
  output logic [DATA_W-1:0] result,
  output logic              divZero
);

  logic regNz, xNz;

  always_comb begin
    regNz   = (regVal != '0);
    xNz     = (xVal != '0);
    divZero = (op == OP_DIV) && !xNz;
    case (op)
      OP_ADD: result = regVal + xVal;
      OP_SUB: result = regVal - xVal;
      OP_MUL: result = regVal * xVal;
      OP_DIV: result = xNz ? DATA_W'($signed(regVal) / $signed(xVal)) : regVal;
      OP_AND: result = {{(DATA_W-1){1'b0}}, regNz && xNz};
      OP_OR:  result = {{(DATA_W-1){1'b0}}, regNz || xNz};
      OP_NOT: result = ~regVal;
      OP_CPZ: result = {{(DATA_W-1){1'b0}}, !xNz};
      OP_CPL: result = {{(DATA_W-1){1'b0}}, xVal[DATA_W-1]};
      default: result = xVal;  // LOD value, jump target
    endcase
  end

endmodule

// File: rtl/toy_datapath.sv
module toy_datapath
  import toy_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output opcode_e           opcode,
  output amode_e            mode,
  output logic [1:0]        regSel,
  output logic              divZero,
  output logic [ADDR_W-1:0] dbgPc,
  output logic [DATA_W-1:0] dbgIr,
  output logic [DATA_W-1:0] dbgR0,
  output logic [DATA_W-1:0] dbgR1,
  output logic [DATA_W-1:0] dbgR2
);

  localparam int IMM_W = DATA_W - 8;
  localparam int EXT_W = DATA_W - IMM_W;
  localparam int NREG  = 3;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] regFile [NREG];
  logic [IMM_W-1:0]  field;
  logic [DATA_W-1:0] regVal, xVal, aluRes, resQ;
  logic              aluDivZero, divZeroQ, jumpQ, takeJump;
  logic [ADDR_W-1:0] stoAddrQ;

  assign opcode = opcode_e'(ir[DATA_W-1 -: 4]);
  assign mode   = amode_e'(ir[DATA_W-5 -: 2]);
  assign regSel = ir[DATA_W-7 -: 2];
  assign field  = ir[IMM_W-1:0];

  always_comb begin
    case (regSel)
      2'd0:    regVal = regFile[0];
      2'd1:    regVal = regFile[1];
      2'd2:    regVal = regFile[2];
      default: regVal = '0;
    endcase
    case (mode)
      AM_ACC:  xVal = regFile[0];
      AM_IMM:  xVal = {{EXT_W{field[IMM_W-1]}}, field};
      AM_DIR:  xVal = memRdata;
      default: xVal = '0;
    endcase
    takeJump = (opcode == OP_JMP) || ((opcode == OP_JMZ) && (regVal == '0));
  end

  toy_alu #(.DATA_W(DATA_W)) i_alu (
    .op      (opcode),
    .regVal  (regVal),
    .xVal    (xVal),
    .result  (aluRes),
    .divZero (aluDivZero)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc       <= '0;
      ir       <= '0;
      resQ     <= '0;
      divZeroQ <= 1'b0;
      jumpQ    <= 1'b0;
      stoAddrQ <= '0;
    end else begin
      if (strobe.irLoad) begin
        ir <= memRdata;
        pc <= pc + 1'b1;
      end
      if (strobe.exLatch) begin
        resQ     <= aluRes;
        divZeroQ <= aluDivZero;
        jumpQ    <= takeJump;
        stoAddrQ <= (mode == AM_DIR) ? field[ADDR_W-1:0] : regFile[0][ADDR_W-1:0];
      end
      if (strobe.commit && jumpQ) pc <= resQ[ADDR_W-1:0];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        regFile[g] <= '0;
      else if (strobe.commit && writesReg(opcode) && !divZeroQ && regSel == 2'(g))
        regFile[g] <= resQ;
    end
  end

  always_comb begin
    if (strobe.opRead)      memAddr = field[ADDR_W-1:0];
    else if (strobe.commit) memAddr = stoAddrQ;
    else                    memAddr = pc;
  end

  assign memWe    = strobe.commit && (opcode == OP_STO);
  assign memWdata = regVal;
  assign divZero  = divZeroQ;
  assign dbgPc    = pc;
  assign dbgIr    = ir;
  assign dbgR0    = regFile[0];
  assign dbgR1    = regFile[1];
  assign dbgR2    = regFile[2];

endmodule

// File: rtl/toy_ctrl.sv
module toy_ctrl
  import toy_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  opcode_e    opcode,
  input  amode_e     mode,
  input  logic [1:0] regSel,
  input  logic       divZero,
  output strobe_t    strobe,
  output logic       halted,
  output logic       errFlag
);

  state_e state, stateNext;
  logic   illegal, setErr;

  always_comb begin
    illegal = (opcode == OP_BAD)
           || ((opcode != OP_NOP) && (opcode != OP_HLT) && (mode == AM_BAD))
           || ((opcode == OP_STO) && (mode == AM_IMM))
           || ((opcode != OP_NOP) && (opcode != OP_HLT) && (opcode != OP_JMP)
               && (regSel == 2'b11));
  end

  always_comb begin
    strobe    = '0;
    setErr    = 1'b0;
    stateNext = state;
    case (state)
      ST_FETCH:    stateNext = ST_DECODE;
      ST_DECODE: begin
        strobe.irLoad = 1'b1;
        stateNext     = ST_OPERAND;
      end
      ST_OPERAND: begin
        strobe.opRead = 1'b1;
        if (illegal) begin
          setErr    = 1'b1;
          stateNext = ST_HALT;
        end else begin
          stateNext = ST_EXECUTE;
        end
      end
      ST_EXECUTE: begin
        strobe.exLatch = 1'b1;
        stateNext      = ST_WRITEBACK;
      end
      ST_WRITEBACK: begin
        strobe.commit = 1'b1;
        setErr        = divZero;
        stateNext     = (opcode == OP_HLT) ? ST_HALT : ST_FETCH;
      end
      default:     stateNext = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_FETCH;
      errFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (setErr) errFlag <= 1'b1;
    end
  end

  assign halted = (state == ST_HALT);

endmodule

// File: rtl/toy_cpu.sv
module toy_cpu
  import toy_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              halted,
  output logic              errFlag,
  output logic [ADDR_W-1:0] dbgPc,
  output logic [DATA_W-1:0] dbgIr,
  output logic [DATA_W-1:0] dbgR0,
  output logic [DATA_W-1:0] dbgR1,
  output logic [DATA_W-1:0] dbgR2
);

  strobe_t    strobe;
  opcode_e    opcode;
  amode_e     mode;
  logic [1:0] regSel;
  logic       divZero;

  toy_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opcode  (opcode),
    .mode    (mode),
    .regSel  (regSel),
    .divZero (divZero),
    .strobe  (strobe),
    .halted  (halted),
    .errFlag (errFlag)
  );

  toy_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .opcode   (opcode),
    .mode     (mode),
    .regSel   (regSel),
    .divZero  (divZero),
    .dbgPc    (dbgPc),
    .dbgIr    (dbgIr),
    .dbgR0    (dbgR0),
    .dbgR1    (dbgR1),
    .dbgR2    (dbgR2)
  );

endmodule

// File: rtl/toy_cpu_checker.sv
module toy_cpu_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              halted,
  input logic              errFlag,
  input logic              memWe,
  input logic [3:0]        irOp,
  input logic [ADDR_W-1:0] dbgPc,
  input logic [DATA_W-1:0] dbgR0,
  input logic [DATA_W-1:0] dbgR1,
  input logic [DATA_W-1:0] dbgR2
);

  p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && $stable(dbgPc) && $stable(dbgR0) && $stable(dbgR1) && $stable(dbgR2));

  p_halt_no_store_r10: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memWe);

  p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  p_store_only_sto_r8: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (irOp == 4'b0101));

  p_one_reg_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones({dbgR0 != $past(dbgR0), dbgR1 != $past(dbgR1), dbgR2 != $past(dbgR2)}) <= 1);

endmodule

bind toy_cpu toy_cpu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_toyCheck (
  .clk     (clk),
  .rstN    (rstN),
  .halted  (halted),
  .errFlag (errFlag),
  .memWe   (memWe),
  .irOp    (dbgIr[DATA_W-1 -: 4]),
  .dbgPc   (dbgPc),
  .dbgR0   (dbgR0),
  .dbgR1   (dbgR1),
  .dbgR2   (dbgR2)
);

// File: tb/test_toy_cpu.sv
`timescale 1ns/1ps
module test_toy_cpu;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int DEPTH = 16;
  localparam logic [1:0] MA = 2'b00, MI = 2'b01, MD = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] memAddr;
  logic          memWe, halted, errFlag;
  logic [DW-1:0] memWdata, memRdata, dbgIr, dbgR0, dbgR1, dbgR2;
  logic [AW-1:0] dbgPc;

  logic [DW-1:0] mem [DEPTH];
  logic          ldEn = 1'b0;
  logic [AW-1:0] ldAddr = '0;
  logic [DW-1:0] ldData = '0;
  int            nRun = 0, nFail = 0, haltStores = 0;

  toy_cpu i_toy_cpu (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .halted(halted), .errFlag(errFlag), .dbgPc(dbgPc),
    .dbgIr(dbgIr), .dbgR0(dbgR0), .dbgR1(dbgR1), .dbgR2(dbgR2)
  );

  always @(posedge clk) begin
    if (ldEn) mem[ldAddr] <= ldData;
    else if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
    if (rstN && halted && memWe) haltStores++;
  end

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  md;
    logic [31:0] init;
    logic [31:0] x;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{4'h6, 2'b01, 32'd5,         32'd7,         32'd12},
    '{4'h7, 2'b10, 32'd5,         32'd7,         32'hFFFFFFFE},
    '{4'h8, 2'b00, 32'hFFFFFFFD,  32'd6,         32'hFFFFFFEE},
    '{4'h9, 2'b01, 32'hFFFFFFF9,  32'd2,         32'hFFFFFFFD},
    '{4'hA, 2'b01, 32'd4,         32'd0,         32'd0},
    '{4'hA, 2'b10, 32'd4,         32'd9,         32'd1},
    '{4'hB, 2'b00, 32'd0,         32'd0,         32'd0},
    '{4'hB, 2'b01, 32'd0,         32'd5,         32'd1},
    '{4'hC, 2'b01, 32'h000000F0,  32'd3,         32'hFFFFFF0F},
    '{4'hD, 2'b10, 32'd9,         32'd0,         32'd1},
    '{4'hD, 2'b01, 32'd9,         32'd2,         32'd0},
    '{4'hE, 2'b01, 32'd0,         32'hFFFFFFFF,  32'd1},
    '{4'hE, 2'b10, 32'd0,         32'h7FFFFFFF,  32'd0},
    '{4'h4, 2'b01, 32'd1,         32'hFFFFFFFB,  32'hFFFFFFFB},
    '{4'h7, 2'b10, 32'h80000000,  32'd1,         32'h7FFFFFFF},
    '{4'h6, 2'b00, 32'd10,        32'd20,        32'd30}
  };

  function automatic logic [31:0] enc(logic [3:0] op, logic [1:0] md, logic [1:0] rs,
                                      logic [23:0] f);
    return {op, md, rs, f};
  endfunction

  function automatic string tagOf(logic [3:0] op);
    if (op >= 4'h6 && op <= 4'h9) return "R5";
    if (op == 4'hA || op == 4'hB) return "R6";
    if (op >= 4'hC && op <= 4'hE) return "R7";
    return "R3";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(int a, logic [31:0] d);
    @(negedge clk);
    ldEn = 1'b1; ldAddr = AW'(a); ldData = d;
    @(posedge clk);
    #1 ldEn = 1'b0;
  endtask

  task automatic holdReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) poke(i, 32'h0);
  endtask

  task automatic runProg(output int cyc);
    @(negedge clk);
    rstN = 1'b1;
    cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (halted) break;
      if (cyc >= 2000) begin
        nRun++; nFail++;
        $display("FAIL watchdog: actual no halt expected halt");
        break;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] f;
    logic [31:0] savePc, s0, s1, s2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: state under reset
    check("R2 pc", 32'(dbgPc), 32'h0);
    check("R2 ir", dbgIr, 32'h0);
    check("R2 regs", dbgR0 | dbgR1 | dbgR2, 32'h0);
    check("R2 flags", {30'h0, halted, errFlag}, 32'h0);
    check("R2 first fetch address", 32'(memAddr), 32'h0);

    // Table: one operation per program, operands from memory words 12 and 13
    for (int v = 0; v < 16; v++) begin
      holdReset();
      f = (VECS[v].md == MI) ? {8'h0, VECS[v].x[23:0]} : (VECS[v].md == MD) ? 32'd12 : 32'd0;
      poke(0, enc(4'h4, MD, 2'd1, 24'd13));
      poke(1, enc(4'h4, MD, 2'd0, 24'd12));
      poke(2, enc(VECS[v].op, VECS[v].md, 2'd1, f[23:0]));
      poke(3, enc(4'h1, MA, 2'd0, 24'd0));
      poke(12, VECS[v].x);
      poke(13, VECS[v].init);
      runProg(cyc);
      check(tagOf(VECS[v].op), dbgR1, VECS[v].exp);
      check("R3 direct load into R0", dbgR0, VECS[v].x);
      check("R1 four instructions", 32'(cyc), 32'd20);
      check("R12 no error", {31'h0, errFlag}, 32'h0);
    end

    // R4: register select
    holdReset();
    poke(0, enc(4'h4, MI, 2'd0, 24'd1));
    poke(1, enc(4'h4, MI, 2'd1, 24'd2));
    poke(2, enc(4'h4, MI, 2'd2, 24'd3));
    poke(3, enc(4'h6, MA, 2'd1, 24'd0));
    poke(4, enc(4'h1, MA, 2'd0, 24'd0));
    runProg(cyc);
    check("R4 R0", dbgR0, 32'd1);
    check("R4 R1", dbgR1, 32'd3);
    check("R4 R2", dbgR2, 32'd3);

    // R8: stores by direct and accumulator address
    holdReset();
    poke(0, enc(4'h4, MI, 2'd2, 24'hFFFFF7));
    poke(1, enc(4'h5, MD, 2'd2, 24'd10));
    poke(2, enc(4'h4, MI, 2'd0, 24'd11));
    poke(3, enc(4'h5, MA, 2'd2, 24'd0));
    poke(4, enc(4'h1, MA, 2'd0, 24'd0));
    runProg(cyc);
    check("R8 direct store", mem[10], 32'hFFFFFFF7);
    check("R8 accumulator store", mem[11], 32'hFFFFFFF7);
    check("R8 no stray write", mem[12], 32'h0);

    // R9: jumps
    holdReset();
    poke(0, enc(4'h4, MI, 2'd1, 24'd0));
    poke(1, enc(4'h3, MI, 2'd1, 24'd4));
    poke(2, enc(4'h4, MI, 2'd0, 24'd99));
    poke(3, enc(4'h1, MA, 2'd0, 24'd0));
    poke(4, enc(4'h4, MI, 2'd2, 24'd1));
    poke(5, enc(4'h3, MI, 2'd2, 24'd2));
    poke(6, enc(4'h2, MI, 2'd3, 24'd8));
    poke(7, enc(4'h4, MI, 2'd0, 24'd77));
    poke(8, enc(4'h4, MI, 2'd1, 24'd5));
    poke(9, enc(4'h1, MA, 2'd0, 24'd0));
    runProg(cyc);
    check("R9 skipped loads", dbgR0, 32'd0);
    check("R9 target reached", dbgR1, 32'd5);
    check("R9 untaken branch", dbgR2, 32'd1);
    check("R9 pc after halt", 32'(dbgPc), 32'd10);
    check("R1 seven instructions", 32'(cyc), 32'd35);

    // R10: frozen after halt
    savePc = 32'(dbgPc); s0 = dbgR0; s1 = dbgR1; s2 = dbgR2;
    haltStores = 0;
    repeat (20) @(negedge clk);
    check("R10 halted", {31'h0, halted}, 32'd1);
    check("R10 pc frozen", 32'(dbgPc), savePc);
    check("R10 regs frozen", dbgR0 ^ dbgR1 ^ dbgR2, s0 ^ s1 ^ s2);
    check("R10 no store", 32'(haltStores), 32'd0);

    // R11: illegal encodings
    for (int k = 0; k < 4; k++) begin
      holdReset();
      poke(0, enc(4'h4, MI, 2'd0, 24'd3));
      case (k)
        0: poke(1, enc(4'hF, MI, 2'd0, 24'd0));
        1: poke(1, enc(4'h6, 2'b11, 2'd0, 24'd0));
        2: poke(1, enc(4'h5, MI, 2'd0, 24'd5));
        default: poke(1, enc(4'h6, MI, 2'd3, 24'd1));
      endcase
      poke(2, enc(4'h4, MI, 2'd1, 24'd9));
      runProg(cyc);
      check("R11 halt cycle", 32'(cyc), 32'd8);
      check("R11 error flag", {31'h0, errFlag}, 32'd1);
      check("R11 R0 kept", dbgR0, 32'd3);
      check("R11 no store", mem[5], 32'h0);
    end

    // R11: NOP ignores mode 11 and register 11
    holdReset();
    poke(0, enc(4'h0, 2'b11, 2'd3, 24'hABCDEF));
    poke(1, enc(4'h1, 2'b11, 2'd3, 24'd0));
    runProg(cyc);
    check("R11 ignored fields", {31'h0, errFlag}, 32'd0);
    check("R1 two instructions", 32'(cyc), 32'd10);

    // R12 / R13: divide by zero
    holdReset();
    poke(0, enc(4'h4, MI, 2'd1, 24'd8));
    poke(1, enc(4'h9, MI, 2'd1, 24'd0));
    poke(2, enc(4'h4, MI, 2'd2, 24'd4));
    poke(3, enc(4'h1, MA, 2'd0, 24'd0));
    runProg(cyc);
    check("R12 register kept", dbgR1, 32'd8);
    check("R12 execution continued", dbgR2, 32'd4);
    check("R12 flag", {31'h0, errFlag}, 32'd1);
    repeat (10) @(negedge clk);
    check("R13 flag sticky", {31'h0, errFlag}, 32'd1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R13 cleared by reset", {31'h0, errFlag}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule